// File: doc/BRIEF.md
# Ping-pong DMA channel chaining controller

This block sits between a converter section and two DMA request channels and keeps a stream of samples moving without gaps. Each converter event (an A/D result becoming ready, or a D/A output tick) is held in a one-word pipeline stage. The block raises a request on the active channel whenever that stage needs servicing. For A/D it needs servicing when it holds a result waiting to go to memory; for D/A it needs servicing when it is empty and waiting for a word from memory.

When the active channel reports terminal count together with an accepted acknowledge, two things can happen. With chaining enabled, the block moves its requests to the other channel at once and sets a sticky interrupt flag, so software can reprogram the channel that has just gone idle. Without chaining, the operation stops and a done flag is set. Chaining goes on, alternating between the channels, for as long as the chaining enable stays high. An A/D result that arrives while the stage is still full is an overrun error. A D/A tick that arrives while the stage is empty is a late-data error. Both set one sticky error flag.

Top module: `dma_pingpong_ctrl`

## Requirements
- R1: After synchronous reset, req_o is 0 and busy_o, done_o, err_o, irq_o and active_o are all 0.
- R2: A start pulse is ignored while xfer_mode_i is 2'b00 (no DMA). A start pulse is also ignored while an operation is busy, and the active channel then keeps its value.
- R3: In the A/D modes (xfer_mode_i 2'b01 clocked, 2'b11 triggered scan) a sample pulse fills the stage, and from the next cycle req_o carries a one on bit active_o. The request stays asserted until an acknowledge is accepted on that channel, and it is low in the cycle after that acknowledge.
- R4: In D/A mode (xfer_mode_i 2'b10) the active channel is requested from the cycle after start. An accepted acknowledge fills the stage and removes the request. A tick empties the stage, and the request returns from the next cycle.
- R5: At most one bit of req_o is high, and a high bit always matches active_o. req_o bit 0 is channel 0.
- R6: With chain_en_i high, terminal count on an accepted acknowledge toggles active_o in the next cycle while busy_o stays high. A start pulse selects channel 0.
- R7: Each channel switch sets irq_o. irq_o then stays high until an irq_ack_i pulse, and a switch in the same cycle as irq_ack_i leaves it set.
- R8: With chain_en_i low, terminal count on an accepted acknowledge clears busy_o, sets done_o and leaves active_o unchanged.
- R9: In the A/D modes, a sample while the stage is full and no acknowledge is accepted in that cycle sets err_o. A sample in the same cycle as an accepted acknowledge does not set it.
- R10: In D/A mode, a tick while the stage is empty sets err_o.
- R11: A clear pulse resets done_o and err_o and leaves irq_o unchanged.
- R12: An A/D sample that arrives in the same cycle as a switching terminal count is requested on the new channel from the next cycle.
- R13: An acknowledge or terminal count on a channel whose request is low has no effect on active_o, busy_o or irq_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_mode_i | input | 2 | Transfer mode, latched at start |
| chain_en_i | input | 1 | Enables automatic channel alternation |
| start_i | input | 1 | Start pulse |
| clear_i | input | 1 | Clears done and error flags |
| irq_ack_i | input | 1 | Write-one-to-clear for the interrupt flag |
| sample_i | input | 1 | A/D result ready or D/A output tick |
| ack_i | input | 2 | Per-channel acknowledge |
| tc_i | input | 2 | Per-channel terminal count, qualified by acknowledge |
| req_o | output | 2 | Per-channel request |
| active_o | output | 1 | Channel currently served |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Sticky operation-complete flag |
| err_o | output | 1 | Sticky overrun / late-data flag |
| irq_o | output | 1 | Sticky switch interrupt flag |

## Verification
The hardest situation to reach from the ports is a converter event that lands in exactly the cycle where the active channel accepts its final word and hands over, because the request then has to reappear on the other channel and not on the old one. The bench drives the sample pulse in the same cycle as the acknowledge and terminal count. It then checks which bit of req_o rises. A sweep over every transfer mode, with chaining both on and off and buffer lengths from one to three, walks the handoff sequence. In each run chaining is dropped before the last buffer, so the run ends after an odd number of buffers.

// File: rtl/dma_pp_pkg.sv
package dma_pp_pkg;
  typedef enum logic [1:0] {
    XF_NONE     = 2'b00,
    XF_ADC_CLK  = 2'b01,
    XF_DAC_CLK  = 2'b10,
    XF_ADC_SCAN = 2'b11
  } xfer_mode_e;

  localparam int unsigned CH_COUNT = 2;
  localparam int unsigned CH_W     = 1;
endpackage

// File: rtl/dma_pp_slot.sv
module dma_pp_slot (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic run,
  input  logic to_mem,
  input  logic sample_i,
  input  logic ack_hit,
  input  logic clear_i,
  output logic want_req,
  output logic err_q
);
  logic full_q;
  logic full_d;
  logic err_evt;

  always_comb begin
    full_d = full_q;
    if (arm) begin
      full_d = 1'b0;
    end else if (run) begin
      if (to_mem) full_d = (full_q & ~ack_hit) | sample_i;
      else        full_d = (full_q | ack_hit) & ~sample_i;
    end
  end

  assign err_evt  = run & sample_i & (to_mem ? (full_q & ~ack_hit) : ~full_q);
  assign want_req = run & (to_mem ? full_q : ~full_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      full_q <= full_d;
      if (err_evt)      err_q <= 1'b1;
      else if (clear_i) err_q <= 1'b0;
    end
  end

  a_r9_overrun: assert property (@(posedge clk) disable iff (rst)
    (run && to_mem && sample_i && full_q && !ack_hit) |=> err_q);
  a_r10_late: assert property (@(posedge clk) disable iff (rst)
    (run && !to_mem && sample_i && !full_q) |=> err_q);
  a_r11_err_clear: assert property (@(posedge clk) disable iff (rst)
    (clear_i && !(run && sample_i)) |=> !err_q);
endmodule

// File: rtl/dma_pp_seq.sv
module dma_pp_seq (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic tc_hit,
  input  logic chain_en,
  input  logic clear_i,
  input  logic irq_ack_i,
  output logic busy_q,
  output logic active_q,
  output logic done_q,
  output logic irq_q
);
  logic do_switch;
  logic do_end;

  assign do_switch = tc_hit & chain_en;
  assign do_end    = tc_hit & ~chain_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      active_q <= 1'b0;
      done_q   <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      if (arm)         busy_q <= 1'b1;
      else if (do_end) busy_q <= 1'b0;

      if (arm)            active_q <= 1'b0;
      else if (do_switch) active_q <= ~active_q;

      if (do_end)       done_q <= 1'b1;
      else if (clear_i) done_q <= 1'b0;

      if (do_switch)      irq_q <= 1'b1;
      else if (irq_ack_i) irq_q <= 1'b0;
    end
  end

  a_r6_toggle: assert property (@(posedge clk) disable iff (rst)
    (do_switch && !arm) |=> (active_q != $past(active_q)) && busy_q);
  a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
    (irq_q && !irq_ack_i) |=> irq_q);
  a_r8_end: assert property (@(posedge clk) disable iff (rst)
    (do_end && !arm) |=> !busy_q && done_q && $stable(active_q));
endmodule

// File: rtl/dma_pp_reqdec.sv
module dma_pp_reqdec
  import dma_pp_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                want_req,
  input  logic                active,
  input  logic [CH_COUNT-1:0] ack_i,
  input  logic [CH_COUNT-1:0] tc_i,
  output logic [CH_COUNT-1:0] req,
  output logic                ack_hit,
  output logic                tc_hit
);
  for (genvar c = 0; c < CH_COUNT; c++) begin : g_ch
    assign req[c] = want_req & (active == CH_W'(c));
  end

  assign ack_hit = |(ack_i & req);
  assign tc_hit  = |(ack_i & tc_i & req);

  a_r5_onehot: assert property (@(posedge clk) disable iff (rst) $onehot0(req));
  a_r13_tc_needs_req: assert property (@(posedge clk) disable iff (rst)
    tc_hit |-> ack_hit);
endmodule

// File: rtl/dma_pingpong_ctrl.sv
module dma_pingpong_ctrl
  import dma_pp_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          xfer_mode_i,
  input  logic                chain_en_i,
  input  logic                start_i,
  input  logic                clear_i,
  input  logic                irq_ack_i,
  input  logic                sample_i,
  input  logic [CH_COUNT-1:0] ack_i,
  input  logic [CH_COUNT-1:0] tc_i,
  output logic [CH_COUNT-1:0] req_o,
  output logic                active_o,
  output logic                busy_o,
  output logic                done_o,
  output logic                err_o,
  output logic                irq_o
);
  xfer_mode_e mode_q;
  logic arm, to_mem, want_req, ack_hit, tc_hit;
  logic busy_q, active_q;

  assign arm    = start_i & ~busy_q & (xfer_mode_e'(xfer_mode_i) != XF_NONE);
  assign to_mem = (mode_q != XF_DAC_CLK);

  always_ff @(posedge clk) begin
    if (rst)      mode_q <= XF_NONE;
    else if (arm) mode_q <= xfer_mode_e'(xfer_mode_i);
  end

  dma_pp_slot i_slot (
    .clk(clk), .rst(rst), .arm(arm), .run(busy_q), .to_mem(to_mem),
    .sample_i(sample_i), .ack_hit(ack_hit), .clear_i(clear_i),
    .want_req(want_req), .err_q(err_o)
  );

  dma_pp_seq i_seq (
    .clk(clk), .rst(rst), .arm(arm), .tc_hit(tc_hit), .chain_en(chain_en_i),
    .clear_i(clear_i), .irq_ack_i(irq_ack_i), .busy_q(busy_q),
    .active_q(active_q), .done_q(done_o), .irq_q(irq_o)
  );

  dma_pp_reqdec i_dec (
    .clk(clk), .rst(rst), .want_req(want_req), .active(active_q),
    .ack_i(ack_i), .tc_i(tc_i), .req(req_o), .ack_hit(ack_hit), .tc_hit(tc_hit)
  );

  assign busy_o   = busy_q;
  assign active_o = active_q;

  a_r2_idle_mode: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && xfer_mode_i == 2'b00) |=> !busy_o);
  a_r2_busy_hold: assert property (@(posedge clk) disable iff (rst)
    (busy_o && req_o == '0) |=> $stable(active_o));
  a_r5_match: assert property (@(posedge clk) disable iff (rst)
    (req_o != '0) |-> req_o[active_o]);
endmodule

// File: tb/test_dma_pingpong_ctrl.sv
`timescale 1ns/1ps
module test_dma_pingpong_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] xfer_mode_i = 2'b00;
  logic chain_en_i = 1'b0, start_i = 1'b0, clear_i = 1'b0, irq_ack_i = 1'b0, sample_i = 1'b0;
  logic [1:0] ack_i = 2'b00, tc_i = 2'b00;
  logic [1:0] req_o;
  logic active_o, busy_o, done_o, err_o, irq_o;
  int n_cmp = 0, n_bad = 0, cyc_cnt = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dma_pingpong_ctrl i_dma_pingpong_ctrl (
    .clk(clk), .rst(rst), .xfer_mode_i(xfer_mode_i), .chain_en_i(chain_en_i),
    .start_i(start_i), .clear_i(clear_i), .irq_ack_i(irq_ack_i), .sample_i(sample_i),
    .ack_i(ack_i), .tc_i(tc_i), .req_o(req_o), .active_o(active_o), .busy_o(busy_o),
    .done_o(done_o), .err_o(err_o), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
    start_i = 0; clear_i = 0; irq_ack_i = 0; sample_i = 0; ack_i = 0; tc_i = 0;
  endtask

  task automatic do_reset();
    rst = 1; cyc(); cyc(); rst = 0;
  endtask

  task automatic run_case(input int m, input int dual, input int len);
    int nbuf;
    int expch;
    bit last_xfer;
    nbuf = dual ? 3 : 1;
    xfer_mode_i = 2'(m); chain_en_i = 1'(dual); start_i = 1; cyc();
    chk("R6 start selects ch0", active_o, 0);
    chk("R6 busy after start", busy_o, 1);
    for (int b = 0; b < nbuf; b++) begin
      if (dual && b == nbuf - 1) chain_en_i = 0;
      expch = b % 2;
      for (int t = 0; t < len; t++) begin
        last_xfer = (b == nbuf - 1) && (t == len - 1);
        if (m != 2) begin
          sample_i = 1; cyc();
          chk("R3 request on active", req_o, 1 << expch);
        end else begin
          chk("R4 request while empty", req_o, 1 << expch);
        end
        ack_i = 2'(1 << expch);
        tc_i  = (t == len - 1) ? 2'(1 << expch) : 2'b00;
        cyc();
        chk(m != 2 ? "R3 drop after ack" : "R4 drop after fill", req_o, 0);
        if (t == len - 1) begin
          if (!last_xfer) begin
            chk("R6 switched channel", active_o, (b + 1) % 2);
            chk("R6 still busy", busy_o, 1);
            chk("R7 irq on switch", irq_o, 1);
            irq_ack_i = 1; cyc();
            chk("R7 irq cleared", irq_o, 0);
          end else begin
            chk("R8 busy ends", busy_o, 0);
            chk("R8 done set", done_o, 1);
            chk("R8 active kept", active_o, expch);
            chk("R8 no irq", irq_o, 0);
          end
        end
        if (m == 2 && !last_xfer) begin
          sample_i = 1; cyc();
        end
      end
    end
    chk("R9 R10 no error in clean run", err_o, 0);
    clear_i = 1; cyc();
    chk("R11 done cleared", done_o, 0);
  endtask

  initial begin
    do_reset();
    chk("R1 req", req_o, 0); chk("R1 busy", busy_o, 0); chk("R1 done", done_o, 0);
    chk("R1 err", err_o, 0); chk("R1 irq", irq_o, 0); chk("R1 active", active_o, 0);

    xfer_mode_i = 2'b00; start_i = 1; cyc();
    chk("R2 no-DMA start ignored", busy_o, 0);
    chk("R2 no-DMA no req", req_o, 0);

    for (int m = 1; m <= 3; m++)
      for (int d = 0; d <= 1; d++)
        for (int l = 1; l <= 3; l++)
          run_case(m, d, l);

    // R2: start while busy keeps active channel
    do_reset();
    xfer_mode_i = 2'b10; chain_en_i = 1; start_i = 1; cyc();
    ack_i = 2'b01; tc_i = 2'b01; cyc();
    chk("R6 D/A switch", active_o, 1);
    start_i = 1; cyc();
    chk("R2 start while busy ignored", active_o, 1);
    // R7: switch in same cycle as irq_ack keeps irq set
    sample_i = 1; cyc();
    chk("R4 request on ch1", req_o, 2);
    irq_ack_i = 1; ack_i = 2'b10; tc_i = 2'b10; cyc();
    chk("R7 set wins over ack", irq_o, 1);
    chk("R6 back to ch0", active_o, 0);
    // R11: clear leaves irq
    clear_i = 1; cyc();
    chk("R11 irq kept on clear", irq_o, 1);

    // R13: ack/tc on unrequested channels
    do_reset();
    xfer_mode_i = 2'b01; chain_en_i = 1; start_i = 1; cyc();
    ack_i = 2'b01; tc_i = 2'b01; cyc();
    chk("R13 no req: active", active_o, 0);
    chk("R13 no req: irq", irq_o, 0);
    chk("R13 no req: busy", busy_o, 1);
    sample_i = 1; cyc();
    ack_i = 2'b10; tc_i = 2'b10; cyc();
    chk("R13 wrong channel: req kept", req_o, 1);
    chk("R13 wrong channel: active", active_o, 0);
    // R9: sample with accepted ack is fine
    sample_i = 1; ack_i = 2'b01; cyc();
    chk("R9 sample with ack no error", err_o, 0);
    chk("R3 refilled", req_o, 1);
    // R12: sample during switch served by new channel
    sample_i = 1; ack_i = 2'b01; tc_i = 2'b01; cyc();
    chk("R12 request moves to new ch", req_o, 2);
    chk("R12 active", active_o, 1);
    // R9: overrun
    sample_i = 1; cyc();
    chk("R9 overrun", err_o, 1);
    clear_i = 1; cyc();
    chk("R11 err cleared", err_o, 0);

    // R10: late data
    do_reset();
    xfer_mode_i = 2'b10; chain_en_i = 0; start_i = 1; cyc();
    sample_i = 1; cyc();
    chk("R10 tick while empty", err_o, 1);
    clear_i = 1; cyc();
    chk("R11 err cleared D/A", err_o, 0);

    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc_cnt++;
      if (cyc_cnt > 100000 && !finished) begin
        finished = 1;
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc_cnt, 100000);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end
endmodule